// File: doc/BRIEF.md
# Event Synchronisation Unit

This unit keeps a small table of event words that lightweight threads use to meet one another. A local thread engine or an incoming network request issues one operation per cycle against a chosen event: wait, set, clear or test. A wait on an event that is already set lets the caller proceed and consumes the set. A wait on an unset event records the caller's resume action on that event. A later set then releases that action.

Each event has its own short FIFO of pending actions, so several waiters can park on one event. Each set releases exactly one of them, oldest first. A released action appears as a one-cycle strobe on one of three outputs, with its target value alongside. The three outputs are: resume a local thread, send a resume message to a thread on another processor, or interrupt the host processor. The surrounding logic turns those strobes into run-queue pushes, network packets or interrupt requests.

Top module: `esu_top`

## Requirements
- R1: After reset every event reads unset, every action queue is empty, and no response or action strobe is active.
- R2: A wait (opCode 0) on a set event returns status 1 (proceed) and leaves the event unset.
- R3: A wait on an unset event whose queue holds fewer than 4 actions returns status 2 (suspended) and appends its action to the tail of that event's queue.
- R4: A set (opCode 1) on an event with an empty queue makes the event set, returns status 0 and raises no action strobe.
- R5: A set on an event with a non-empty queue removes the oldest queued action and fires it. The event stays unset and the status is 0. Successive sets release the actions in the order their waits arrived.
- R6: A clear (opCode 2) makes the event unset and returns status 0. It leaves the event's queue untouched, and a clear of an unset event changes nothing.
- R7: A test (opCode 3) returns status 4 if the event is set and 5 if it is unset. It changes neither the flag nor the queue.
- R8: A wait on an unset event whose queue already holds 4 actions returns status 3 (full) and is not enqueued.
- R9: A fired action of kind 0 pulses localGo, kind 1 pulses remoteGo and kind 2 pulses hostIrq. The pulse lasts one cycle and actTarget carries the action's target in that cycle. At most one strobe is active at a time, and a kind-3 action is released with no strobe.
- R10: Each accepted operation produces its response and any strobe exactly one cycle later. An idle cycle produces no response, and operations on different events do not affect one another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 2 | 0 wait, 1 set, 2 clear, 3 test |
| opEvent | input | EV_W | Index of the addressed event |
| opKind | input | 2 | Action kind recorded by a wait |
| opTarget | input | TGT_W | Action target recorded by a wait |
| respValid | output | 1 | Response present |
| respStatus | output | 3 | 0 ok, 1 proceed, 2 suspended, 3 full, 4 is set, 5 is unset |
| localGo | output | 1 | Resume a local thread |
| remoteGo | output | 1 | Send a resume message to a remote thread |
| hostIrq | output | 1 | Interrupt the host processor |
| actTarget | output | TGT_W | Target of the fired action |

## Verification
Several kinds of internal fault stay hidden at first. A flag that is wrongly held, a stale queue pointer or a miscounted queue level produces no bad output on the operation that causes it. The fault shows on a later test, wait or set of the same event: as a wrong status, a missing or extra strobe, or an action released out of order. Long operation sequences that interleave events are therefore compared against a bench model after every response, one cycle after each operation. A fault in one event's storage that leaks into a neighbour appears as a wrong status on the neighbour's next access.

// File: rtl/esu_pkg.sv
package esu_pkg;
  typedef enum logic [1:0] {
    OP_WAIT  = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_TEST  = 2'd3
  } opCode_e;

  typedef enum logic [2:0] {
    ST_OK    = 3'd0,
    ST_GO    = 3'd1,
    ST_SUSP  = 3'd2,
    ST_FULL  = 3'd3,
    ST_ISSET = 3'd4,
    ST_ISCLR = 3'd5
  } status_e;

  localparam logic [1:0] KIND_LOCAL  = 2'd0;
  localparam logic [1:0] KIND_REMOTE = 2'd1;
  localparam logic [1:0] KIND_HOST   = 2'd2;

  typedef struct packed {
    logic setFlag;
    logic clrFlag;
    logic push;
    logic pop;
  } dpStrobe_t;
endpackage

// File: rtl/esu_dpath.sv
module esu_dpath
  import esu_pkg::*;
#(
  parameter int NUM_EV = 4,
  parameter int QDEPTH = 4,
  parameter int TGT_W  = 8,
  localparam int EV_W  = $clog2(NUM_EV),
  localparam int ACT_W = TGT_W + 2,
  localparam int CNT_W = $clog2(QDEPTH + 1),
  localparam int PTR_W = $clog2(QDEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [EV_W-1:0]  selEv,
  input  logic [ACT_W-1:0] pushAct,
  output logic             selFlag,
  output logic             selEmpty,
  output logic             selFull,
  output logic [ACT_W-1:0] headAct
);
  logic             flagV [NUM_EV];
  logic [CNT_W-1:0] cntV  [NUM_EV];
  logic [ACT_W-1:0] headV [NUM_EV];

  for (genvar g = 0; g < NUM_EV; g++) begin : gEv
    logic             flag;
    logic [CNT_W-1:0] cnt;
    logic [PTR_W-1:0] rdP, wrP;
    logic [ACT_W-1:0] mem [QDEPTH];
    logic             hit;

    assign hit = (selEv == EV_W'(g));

    function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(QDEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
      if (!rstN) begin
        flag <= 1'b0;
        cnt  <= '0;
        rdP  <= '0;
        wrP  <= '0;
      end else if (hit) begin
        if (strobe.setFlag) flag <= 1'b1;
        if (strobe.clrFlag) flag <= 1'b0;
        if (strobe.push) begin
          wrP <= nextPtr(wrP);
          cnt <= cnt + 1'b1;
        end
        if (strobe.pop) begin
          rdP <= nextPtr(rdP);
          cnt <= cnt - 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (hit && strobe.push) mem[wrP] <= pushAct;
    end

    assign flagV[g] = flag;
    assign cntV[g]  = cnt;
    assign headV[g] = mem[rdP];

    AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      !(flag && (cnt != '0))); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (hit && strobe.push) |-> (cnt < CNT_W'(QDEPTH))); // R8
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (hit && strobe.pop) |-> (cnt != '0)); // R5
  end

  assign selFlag  = flagV[selEv];
  assign selEmpty = (cntV[selEv] == '0);
  assign selFull  = (cntV[selEv] == CNT_W'(QDEPTH));
  assign headAct  = headV[selEv];
endmodule

// File: rtl/esu_ctrl.sv
module esu_ctrl
  import esu_pkg::*;
#(
  parameter int TGT_W  = 8,
  localparam int ACT_W = TGT_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic             selFlag,
  input  logic             selEmpty,
  input  logic             selFull,
  input  logic [ACT_W-1:0] headAct,
  output dpStrobe_t        strobe,
  output logic             respValid,
  output logic [2:0]       respStatus,
  output logic             localGo,
  output logic             remoteGo,
  output logic             hostIrq,
  output logic [TGT_W-1:0] actTarget
);
  status_e    status;
  logic       fire;
  logic [1:0] headKind;

  assign headKind = headAct[ACT_W-1 -: 2];

  always_comb begin
    strobe = '0;
    status = ST_OK;
    fire   = 1'b0;
    if (opValid) begin
      unique case (opCode_e'(opCode))
        OP_WAIT: begin
          if (selFlag) begin
            strobe.clrFlag = 1'b1;
            status = ST_GO;
          end else if (!selFull) begin
            strobe.push = 1'b1;
            status = ST_SUSP;
          end else begin
            status = ST_FULL;
          end
        end
        OP_SET: begin
          if (!selEmpty) begin
            strobe.pop = 1'b1;
            fire = 1'b1;
          end else begin
            strobe.setFlag = 1'b1;
          end
        end
        OP_CLEAR: strobe.clrFlag = 1'b1;
        OP_TEST:  status = selFlag ? ST_ISSET : ST_ISCLR;
        default:  status = ST_OK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid  <= 1'b0;
      respStatus <= 3'd0;
      localGo    <= 1'b0;
      remoteGo   <= 1'b0;
      hostIrq    <= 1'b0;
      actTarget  <= '0;
    end else begin
      respValid  <= opValid;
      respStatus <= status;
      localGo    <= fire && (headKind == KIND_LOCAL);
      remoteGo   <= fire && (headKind == KIND_REMOTE);
      hostIrq    <= fire && (headKind == KIND_HOST);
      if (fire) actTarget <= headAct[TGT_W-1:0];
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({localGo, remoteGo, hostIrq})); // R9
  AST_STROBE_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (localGo || remoteGo || hostIrq) |-> (respValid && respStatus == ST_OK)); // R5
  AST_FULL_FROM_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == OP_WAIT && selFull && !selFlag) |=> (respStatus == ST_FULL)); // R8
  AST_PUSH_NOT_SET: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> !selFlag); // R3
endmodule

// File: rtl/esu_top.sv
module esu_top
  import esu_pkg::*;
#(
  parameter int NUM_EV = 4,
  parameter int QDEPTH = 4,
  parameter int TGT_W  = 8,
  localparam int EV_W  = $clog2(NUM_EV),
  localparam int ACT_W = TGT_W + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             opValid,
  input  logic [1:0]       opCode,
  input  logic [EV_W-1:0]  opEvent,
  input  logic [1:0]       opKind,
  input  logic [TGT_W-1:0] opTarget,
  output logic             respValid,
  output logic [2:0]       respStatus,
  output logic             localGo,
  output logic             remoteGo,
  output logic             hostIrq,
  output logic [TGT_W-1:0] actTarget
);
  dpStrobe_t        strobe;
  logic             selFlag, selEmpty, selFull;
  logic [ACT_W-1:0] headAct;

  esu_dpath #(.NUM_EV(NUM_EV), .QDEPTH(QDEPTH), .TGT_W(TGT_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .selEv(opEvent),
    .pushAct({opKind, opTarget}), .selFlag(selFlag), .selEmpty(selEmpty),
    .selFull(selFull), .headAct(headAct)
  );

  esu_ctrl #(.TGT_W(TGT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .selFlag(selFlag), .selEmpty(selEmpty), .selFull(selFull),
    .headAct(headAct), .strobe(strobe), .respValid(respValid),
    .respStatus(respStatus), .localGo(localGo), .remoteGo(remoteGo),
    .hostIrq(hostIrq), .actTarget(actTarget)
  );
endmodule

// File: tb/sim_esu_top.sv
`timescale 1ns/1ps
module sim_esu_top;
  localparam int NEV = 4;
  localparam int QD  = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [1:0] opCode = 2'd0;
  logic [1:0] opEvent = 2'd0;
  logic [1:0] opKind = 2'd0;
  logic [7:0] opTarget = 8'd0;
  logic       respValid, localGo, remoteGo, hostIrq;
  logic [2:0] respStatus;
  logic [7:0] actTarget;

  int nChk = 0;
  int nFail = 0;

  bit       mFlag [NEV];
  int       mCnt  [NEV];
  int       mKind [NEV][QD];
  int       mTgt  [NEV][QD];
  int unsigned seed = 32'h1234_5678;

  always #2.5 clk = ~clk;

  esu_top u0 (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opEvent(opEvent), .opKind(opKind), .opTarget(opTarget),
    .respValid(respValid), .respStatus(respStatus), .localGo(localGo),
    .remoteGo(remoteGo), .hostIrq(hostIrq), .actTarget(actTarget)
  );

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runOp(input int code, input int ev, input int kind,
                       input int tgt, input string req);
    int expSt, expStb, expTgt;
    expStb = 0; expTgt = -1;
    case (code)
      0: if (mFlag[ev]) begin expSt = 1; mFlag[ev] = 0; end
         else if (mCnt[ev] < QD) begin
           mKind[ev][mCnt[ev]] = kind; mTgt[ev][mCnt[ev]] = tgt;
           mCnt[ev]++; expSt = 2;
         end else expSt = 3;
      1: begin
           expSt = 0;
           if (mCnt[ev] > 0) begin
             if (mKind[ev][0] < 3) expStb = 1 << mKind[ev][0];
             expTgt = mTgt[ev][0];
             for (int i = 0; i < QD - 1; i++) begin
               mKind[ev][i] = mKind[ev][i+1]; mTgt[ev][i] = mTgt[ev][i+1];
             end
             mCnt[ev]--;
           end else mFlag[ev] = 1;
         end
      2: begin expSt = 0; mFlag[ev] = 0; end
      default: expSt = mFlag[ev] ? 4 : 5;
    endcase
    opValid = 1'b1; opCode = 2'(code); opEvent = 2'(ev);
    opKind = 2'(kind); opTarget = 8'(tgt);
    @(negedge clk);
    opValid = 1'b0;
    chk({req, " respValid"}, int'(respValid), 1);
    chk({req, " status"}, int'(respStatus), expSt);
    chk({req, " strobes"}, int'({hostIrq, remoteGo, localGo}), expStb);
    if (expStb != 0) chk({req, " target"}, int'(actTarget), expTgt);
  endtask

  task automatic idleCheck(input string req);
    @(negedge clk);
    chk({req, " idle respValid"}, int'(respValid), 0);
    chk({req, " idle strobes"}, int'({hostIrq, remoteGo, localGo}), 0);
  endtask

  function automatic int rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return int'(seed[30:16]);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

  initial begin
    for (int e = 0; e < NEV; e++) begin mFlag[e] = 0; mCnt[e] = 0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 respValid", int'(respValid), 0);
    chk("R1 strobes", int'({hostIrq, remoteGo, localGo}), 0);
    for (int e = 0; e < NEV; e++) runOp(3, e, 0, 0, "R1");
    for (int e = 0; e < NEV; e++) runOp(1, e, 0, 0, "R1 empty queue");
    for (int e = 0; e < NEV; e++) runOp(2, e, 0, 0, "R6");

    // R2: wait on set event proceeds and consumes
    runOp(1, 0, 0, 0, "R4");
    runOp(3, 0, 0, 0, "R7");
    runOp(3, 0, 0, 0, "R7 unchanged");
    runOp(0, 0, 1, 9, "R2");
    runOp(3, 0, 0, 0, "R2 consumed");

    // R6: clear on unset, clear keeps queue
    runOp(2, 1, 0, 0, "R6 unset");
    runOp(3, 1, 0, 0, "R6");
    runOp(0, 1, 2, 77, "R3");
    runOp(2, 1, 0, 0, "R6 queue kept");
    runOp(1, 1, 0, 0, "R6 fire after clear");
    idleCheck("R10");

    // R5, R8, R9: fill each event's queue and drain in order, all kinds
    for (int e = 0; e < NEV; e++) begin
      for (int k = 0; k < 3; k++) begin
        for (int s = 0; s < QD; s++)
          runOp(0, e, (k + s) % 3, 16 * e + 4 * k + s, "R3 fill");
        runOp(0, e, k, 200, "R8 full");
        runOp(3, (e + 1) % NEV, 0, 0, "R10 neighbour");
        for (int s = 0; s < QD; s++) runOp(1, e, 0, 0, "R5 R9 release");
        runOp(3, e, 0, 0, "R5 unset after release");
        runOp(1, e, 0, 0, "R4 set after drain");
        runOp(0, e, 0, 0, "R2");
      end
    end

    // R10: long mixed sweep
    for (int i = 0; i < 3000; i++) begin
      int c, r;
      r = rnd();
      c = (r % 8 < 4) ? 0 : (r % 8 < 6) ? 1 : r % 4;
      runOp(c, rnd() % NEV, rnd() % 3, rnd() % 256, "R10 sweep");
      if (i % 97 == 0) idleCheck("R10");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end
endmodule